// File: doc/BRIEF.md
# Flash Power-Mode and Reset Sequencer

This block is the mode controller that sits beside the array of a parallel NOR flash. Each clock it looks at the chip-select, output-enable and write-enable strobes, the active-low hardware reset pin and the address bus. From them it settles which mode the device is in: active read, standby, automatic sleep, pin reset, or recovery after reset. It drives the enable of the data-pin tristate drivers and a holding register for read data. It also drives the ready/busy line, a write-command gate and a return-to-array-read strobe for the command decoder, and an abort pulse for the program/erase engine. The engine reports a busy flag back to it.

Each timing value is a parameter counted in clock cycles. These are the array access time, the extra margin before sleep, the minimum reset pulse width, the two reset recovery bounds and the read hold-off after reset release. Each one is timed by its own synchronous down or up counter. The `mode` output exposes the state, encoded as 0 active, 1 standby, 2 sleep, 3 reset and 4 recovery. A surrounding testbench or a debug monitor can follow every transition through it.

Top module: `fpm_seq_top`

## Requirements
- R1: Once `addr` has held one value for T_ACC+T_MARGIN consecutive rising edges, the block is asleep. With `oe_n` high, `lp_sleep` is 1 whatever `ce_n` and `we_n` are. One edge earlier it is 0.
- R2: While asleep, `data_out` keeps the last captured word even if the array contents change. A changed `addr` ends sleep at the next edge (`mode` = 0). The word for the new address is driven T_ACC edges after that.
- R3: `lp_sleep` is 1 only while `oe_n` is high. With `oe_n` low, a sleeping selected device shows `mode` = 2 and `lp_sleep` = 0.
- R4: With `ce_n` and `hw_rst_n` both high and no engine busy, `mode` = 1 (standby) and `data_oe` = 0, whatever `oe_n` is. After the system reset, the block starts in this state with `ready` = 1 and `cmd_en` = 0.
- R5: While `eng_busy` is 1, a deselected device stays in `mode` = 0. It drops to standby in the cycle after busy clears.
- R6: Once `hw_rst_n` has been low for T_RP consecutive edges, the block enters `mode` = 3 and raises `dec_clr`. `data_oe` and `cmd_en` are forced to 0. If the engine was busy, `eng_abort` pulses for one cycle. A shorter low pulse changes no mode, and `cmd_en` and `data_oe` are 0 only while the pin is low.
- R7: A reset that qualifies while the engine is busy holds `ready` at 0 for T_RDY_BUSY cycles from the qualifying edge. `ready` is 0 whenever `eng_busy` is 1.
- R8: A reset that qualifies with no engine busy leaves `ready` at 1 and raises no `eng_abort`. Recovery ends T_RDY_IDLE+1 edges after the qualifying edge, or T_RH+1 edges after release, whichever is later.
- R9: After `hw_rst_n` returns high, `mode` = 4 and `data_oe` = 0 until the hold-off T_RH and the reset recovery count have both run out. Active mode then returns, and reads need a full T_ACC access before `data_oe` rises.
- R10: With `oe_n` high, `data_oe` = 0 while `ready` keeps being driven.
- R11: When the device is selected with `oe_n` low, `data_oe` rises T_ACC edges after the edge that saw a new address. `data_out` then equals the array word for that address.
- R12: `cmd_en` = 1 exactly when the device is running, `hw_rst_n` is high and `ce_n` and `we_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, already synchronised |
| addr | input | AW | Address bus |
| eng_busy | input | 1 | Program/erase engine busy |
| arr_data | input | DW | Word read from the array at `addr` |
| data_out | output | DW | Held read word for the data pins |
| data_oe | output | 1 | Data-pin driver enable |
| ready | output | 1 | Ready/busy line, 1 = ready |
| cmd_en | output | 1 | Write-command gate to the decoder |
| dec_clr | output | 1 | Return decoder to array read |
| eng_abort | output | 1 | One-cycle abort to the engine |
| lp_sleep | output | 1 | Low-current sleep indication |
| mode | output | 3 | 0 active, 1 standby, 2 sleep, 3 reset, 4 recovery |

## Verification
A wrong pulse-width or recovery count shows at `mode` and `ready` within one cycle of the edge where the count should have ended. Examples are a reset that qualifies one edge early, or a `ready` that rises one cycle late. A stale access counter or holding register shows as `data_oe` rising a cycle too soon, or as a `data_out` word that follows the array during sleep. Both appear on the cycle where the expected and the actual edge differ. The scoreboard therefore pins each expectation to an exact cycle on both sides of every such edge.

// File: rtl/fpm_pkg.sv
// Package: shared encodings for the flash power-mode sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package fpm_pkg;

    // Reported device mode, visible at the top-level mode port.
    typedef enum logic [2:0] {
        FPM_ACTIVE  = 3'd0,
        FPM_STANDBY = 3'd1,
        FPM_SLEEP   = 3'd2,
        FPM_RESET   = 3'd3,
        FPM_RECOV   = 3'd4
    } fpm_mode_e;

    // Internal reset sequencer state.
    typedef enum logic [1:0] {
        RS_RUN   = 2'd0,
        RS_HOLD  = 2'd1,
        RS_RECOV = 2'd2
    } rs_state_e;

endpackage

// File: rtl/fpm_addr_watch.sv
// Module: fpm_addr_watch
// Watches the address bus and reports a change each cycle. Counts how many
// consecutive edges the address has been stable and flags sleep when the
// count reaches T_SLEEP.
// Assumes: T_SLEEP >= 1; clr forces the stability count back to zero.
module fpm_addr_watch #(
    parameter int AW      = 8,
    parameter int T_SLEEP = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          clr,
    output logic          addr_chg,
    output logic          asleep
);
    localparam int CW = $clog2(T_SLEEP + 1);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] stab_cnt;

    // Compare the live bus with the value seen at the last edge.
    assign addr_chg = (addr != addr_q);

    // Register the address and count stable edges, saturating at T_SLEEP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stab_cnt <= '0;
        end else begin
            addr_q <= addr;
            if (clr || addr_chg) begin
                stab_cnt <= '0;
            end else if (stab_cnt != CW'(T_SLEEP)) begin
                stab_cnt <= stab_cnt + 1'b1;
            end
        end
    end

    // Sleep holds once the stability count has saturated.
    assign asleep = (stab_cnt == CW'(T_SLEEP));

endmodule

// File: rtl/fpm_reset_seq.sv
// Module: fpm_reset_seq
// Filters the hardware reset pin for a minimum low width, then runs the
// hold and recovery phases. It times the ready/busy hold after a reset that
// cut an embedded operation short, and the read hold-off after release.
// Assumes: hw_rst_n is synchronous to clk; T_RP, T_RH >= 1.
module fpm_reset_seq
    import fpm_pkg::*;
#(
    parameter int T_RP       = 4,
    parameter int T_RDY_BUSY = 10,
    parameter int T_RDY_IDLE = 3,
    parameter int T_RH       = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hw_rst_n,
    input  logic      eng_busy,
    output rs_state_e state,
    output logic      eng_abort,
    output logic      ready
);
    localparam int WW   = $clog2(T_RP + 1);
    localparam int RMAX = (T_RDY_BUSY > T_RDY_IDLE) ? T_RDY_BUSY : T_RDY_IDLE;
    localparam int RW   = $clog2(RMAX + 1);
    localparam int HW   = $clog2(T_RH + 1);

    logic [WW-1:0] wid_cnt;
    logic [RW-1:0] rdy_cnt;
    logic [HW-1:0] rh_cnt;
    logic          hold_busy;
    logic          qualify;

    // A pulse qualifies on the T_RP-th consecutive low edge.
    assign qualify = !hw_rst_n && (wid_cnt == WW'(T_RP - 1)) && (state != RS_HOLD);

    // Count consecutive low edges of the reset pin, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wid_cnt <= '0;
        end else if (hw_rst_n) begin
            wid_cnt <= '0;
        end else if (wid_cnt != WW'(T_RP - 1)) begin
            wid_cnt <= wid_cnt + 1'b1;
        end
    end

    // Sequence run -> hold -> recovery -> run, with the post-release hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RS_RUN;
            rh_cnt <= '0;
        end else if (qualify) begin
            state <= RS_HOLD;
        end else begin
            case (state)
                RS_HOLD: begin
                    if (hw_rst_n) begin
                        state  <= RS_RECOV;
                        rh_cnt <= HW'(T_RH);
                    end
                end
                RS_RECOV: begin
                    if (rh_cnt == '0 && rdy_cnt == '0) begin
                        state <= RS_RUN;
                    end else if (rh_cnt != '0) begin
                        rh_cnt <= rh_cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Load the internal recovery time at qualification and run it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_cnt   <= '0;
            hold_busy <= 1'b0;
        end else if (qualify) begin
            rdy_cnt   <= eng_busy ? RW'(T_RDY_BUSY) : RW'(T_RDY_IDLE);
            hold_busy <= eng_busy;
        end else if (rdy_cnt != '0) begin
            rdy_cnt <= rdy_cnt - 1'b1;
        end
    end

    // One-cycle abort to the engine when a reset cuts a running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_abort <= 1'b0;
        end else begin
            eng_abort <= qualify && eng_busy;
        end
    end

    // Busy while the engine runs or while an interrupted operation recovers.
    assign ready = !eng_busy && !(hold_busy && (rdy_cnt != '0));

endmodule

// File: rtl/fpm_read_path.sv
// Module: fpm_read_path
// Times each array access and holds the last word read. The word is
// captured at the edge where the access count runs out. The driver enable
// rises once the access is complete and the read is allowed.
// Assumes: T_ACC >= 1; reload restarts the access from the full time.
module fpm_read_path #(
    parameter int DW    = 16,
    parameter int T_ACC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          rd_en,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          valid
);
    localparam int AC = $clog2(T_ACC + 1);

    logic [AC-1:0] acc_cnt;
    logic [DW-1:0] hold_q;

    // Run the access counter and capture the word when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= AC'(T_ACC);
            hold_q  <= '0;
        end else if (reload) begin
            acc_cnt <= AC'(T_ACC);
        end else if (acc_cnt != '0) begin
            acc_cnt <= acc_cnt - 1'b1;
            if (acc_cnt == AC'(1)) begin
                hold_q <= arr_data;
            end
        end
    end

    // The held word is valid once no access is pending.
    assign valid    = (acc_cnt == '0);
    assign data_out = hold_q;
    assign data_oe  = rd_en && valid;

endmodule

// File: rtl/fpm_seq_top.sv
// Module: fpm_seq_top
// Top of the flash power-mode and reset sequencer. Joins the address
// watcher, the reset sequencer and the read path, and derives the reported
// mode, the low-current flag and the decoder gates.
// Assumes: every strobe is synchronous to clk; T_ACC+T_MARGIN >= T_ACC, so a
// word is always captured before sleep is entered.
module fpm_seq_top
    import fpm_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int T_ACC      = 4,
    parameter int T_MARGIN   = 2,
    parameter int T_RP       = 4,
    parameter int T_RDY_BUSY = 10,
    parameter int T_RDY_IDLE = 3,
    parameter int T_RH       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          hw_rst_n,
    input  logic [AW-1:0] addr,
    input  logic          eng_busy,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          ready,
    output logic          cmd_en,
    output logic          dec_clr,
    output logic          eng_abort,
    output logic          lp_sleep,
    output logic [2:0]    mode
);
    localparam int T_SLEEP = T_ACC + T_MARGIN;

    rs_state_e rs_state;
    logic      in_run;
    logic      addr_chg;
    logic      asleep;
    logic      rd_valid;
    logic      rd_reload;
    logic      rd_en;
    fpm_mode_e mode_w;

    // Running means neither holding in reset nor recovering from it.
    assign in_run = (rs_state == RS_RUN);

    fpm_addr_watch #(
        .AW      (AW),
        .T_SLEEP (T_SLEEP)
    ) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .clr      (!in_run),
        .addr_chg (addr_chg),
        .asleep   (asleep)
    );

    fpm_reset_seq #(
        .T_RP       (T_RP),
        .T_RDY_BUSY (T_RDY_BUSY),
        .T_RDY_IDLE (T_RDY_IDLE),
        .T_RH       (T_RH)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_rst_n  (hw_rst_n),
        .eng_busy  (eng_busy),
        .state     (rs_state),
        .eng_abort (eng_abort),
        .ready     (ready)
    );

    // A fresh access is needed after a new address, deselect or any reset.
    assign rd_reload = addr_chg || ce_n || !in_run || !hw_rst_n;
    assign rd_en     = in_run && hw_rst_n && !ce_n && !oe_n;

    fpm_read_path #(
        .DW    (DW),
        .T_ACC (T_ACC)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (rd_reload),
        .rd_en    (rd_en),
        .arr_data (arr_data),
        .data_out (data_out),
        .data_oe  (data_oe),
        .valid    (rd_valid)
    );

    // Mode priority: reset phases, then standby, then sleep, else active.
    always_comb begin
        if (rs_state == RS_HOLD) begin
            mode_w = FPM_RESET;
        end else if (rs_state == RS_RECOV) begin
            mode_w = FPM_RECOV;
        end else if (ce_n && hw_rst_n && !eng_busy) begin
            mode_w = FPM_STANDBY;
        end else if (asleep && rd_valid) begin
            mode_w = FPM_SLEEP;
        end else begin
            mode_w = FPM_ACTIVE;
        end
    end

    assign mode     = mode_w;
    assign lp_sleep = asleep && oe_n && in_run;
    assign cmd_en   = in_run && hw_rst_n && !ce_n && !we_n;
    assign dec_clr  = (rs_state == RS_HOLD);

endmodule

// File: rtl/fpm_seq_chk.sv
// Module: fpm_seq_chk
// Port-level temporal checks for fpm_seq_top, attached by bind below.
// Assumes: the port names match those of fpm_seq_top.
module fpm_seq_chk
    import fpm_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          hw_rst_n,
    input logic [AW-1:0] addr,
    input logic          eng_busy,
    input logic [DW-1:0] arr_data,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic          ready,
    input logic          cmd_en,
    input logic          dec_clr,
    input logic          eng_abort,
    input logic          lp_sleep,
    input logic [2:0]    mode
);

    p_lp_needs_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lp_sleep |-> oe_n);

    p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FPM_STANDBY) |-> (!data_oe && ce_n));

    p_busy_keeps_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && ce_n && mode != FPM_RESET && mode != FPM_RECOV) |-> (mode == FPM_ACTIVE));

    p_reset_silences_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FPM_RESET) |-> (!data_oe && !cmd_en && dec_clr));

    p_pin_low_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |-> (!data_oe && !cmd_en));

    p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_abort);

    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !ready);

    p_release_recovers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FPM_RESET && hw_rst_n) |=> (mode == FPM_RECOV));

    p_recov_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FPM_RECOV) |-> !data_oe);

    p_oe_high_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !data_oe);

    p_sleep_holds_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FPM_SLEEP && $past(mode) == FPM_SLEEP) |-> $stable(data_out));

endmodule

bind fpm_seq_top fpm_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_fpm_seq_top.sv
// Scoreboard bench for fpm_seq_top: driver tasks queue timed expectations,
// a monitor pops and compares them in the cycle they fall due.
module sim_fpm_seq_top;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int T_ACC = 4;
    localparam int T_MARGIN = 2;
    localparam int T_RP = 4;
    localparam int T_RDY_BUSY = 10;
    localparam int T_RDY_IDLE = 3;
    localparam int T_RH = 2;

    localparam int K_MODE = 0, K_READY = 1, K_DOE = 2, K_DOUT = 3,
                   K_LP = 4, K_CMD = 5, K_ABORT = 6, K_DECCLR = 7;
    localparam int M_ACT = 0, M_STBY = 1, M_SLP = 2, M_RST = 3, M_REC = 4;

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          eng_busy = 1'b0;
    logic [DW-1:0] salt = '0;
    logic [DW-1:0] arr_data;
    logic [DW-1:0] data_out;
    logic          data_oe, ready, cmd_en, dec_clr, eng_abort, lp_sleep;
    logic [2:0]    mode;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    // Array model: each word is the address repeated, xored with a salt.
    assign arr_data = {addr, addr} ^ salt;

    fpm_seq_top #(
        .AW(AW), .DW(DW), .T_ACC(T_ACC), .T_MARGIN(T_MARGIN), .T_RP(T_RP),
        .T_RDY_BUSY(T_RDY_BUSY), .T_RDY_IDLE(T_RDY_IDLE), .T_RH(T_RH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hw_rst_n(hw_rst_n), .addr(addr), .eng_busy(eng_busy), .arr_data(arr_data),
        .data_out(data_out), .data_oe(data_oe), .ready(ready), .cmd_en(cmd_en),
        .dec_clr(dec_clr), .eng_abort(eng_abort), .lp_sleep(lp_sleep), .mode(mode)
    );

    function automatic int port_val(int kind);
        case (kind)
            K_MODE:   return int'(mode);
            K_READY:  return int'(ready);
            K_DOE:    return int'(data_oe);
            K_DOUT:   return int'(data_out);
            K_LP:     return int'(lp_sleep);
            K_CMD:    return int'(cmd_en);
            K_ABORT:  return int'(eng_abort);
            default:  return int'(dec_clr);
        endcase
    endfunction

    function automatic int word_of(logic [AW-1:0] a, logic [DW-1:0] s);
        return int'({a, a} ^ s);
    endfunction

    // Driver side: queue an expectation d cycles after the current one.
    task automatic expect_at(int d, int kind, int val, string tag);
        exp_t e;
        e.cyc = cyc + d;
        e.kind = kind;
        e.val = val;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: sample mid-high after each edge, compare all items due now.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    n_cmp++;
                    if (port_val(sb[i].kind) != sb[i].val) begin
                        n_bad++;
                        $display("FAIL %s kind=%0d cyc=%0d actual=%0h expected=%0h",
                                 sb[i].tag, sb[i].kind, cyc,
                                 port_val(sb[i].kind), sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // Reset state: standby, ready, nothing driven (R4).
        expect_at(1, K_MODE, M_STBY, "R4 reset mode");
        expect_at(1, K_READY, 1, "R4 reset ready");
        expect_at(1, K_DOE, 0, "R4 reset doe");
        expect_at(1, K_CMD, 0, "R4 reset cmd");
        expect_at(1, K_LP, 0, "R1 no sleep right after reset");
        tick(10);

        // Read of a new address, then sleep entry with OE low (R11, R1, R3).
        ce_n = 1'b0; oe_n = 1'b0; addr = 8'h35;
        expect_at(T_ACC, K_DOE, 0, "R11 access pending");
        expect_at(T_ACC + 1, K_DOE, 1, "R11 access done");
        expect_at(T_ACC + 1, K_DOUT, word_of(8'h35, 16'h0000), "R11 read word");
        expect_at(T_ACC + T_MARGIN, K_MODE, M_ACT, "R1 not yet asleep");
        expect_at(T_ACC + T_MARGIN + 1, K_MODE, M_SLP, "R1 asleep");
        expect_at(T_ACC + T_MARGIN + 1, K_LP, 0, "R3 oe low no low-current flag");
        tick(8);
        // Array contents change while asleep: held word must not follow (R2).
        salt = 16'h00ff;
        expect_at(2, K_DOUT, word_of(8'h35, 16'h0000), "R2 word held in sleep");
        expect_at(2, K_DOE, 1, "R2 still driven in sleep");
        tick(2);
        oe_n = 1'b1;
        expect_at(1, K_LP, 1, "R3 oe high low-current flag");
        expect_at(1, K_DOE, 0, "R10 oe high tristate");
        expect_at(1, K_READY, 1, "R10 ready still driven");
        tick(1);
        oe_n = 1'b0; addr = 8'h5a;
        expect_at(1, K_MODE, M_ACT, "R2 wake on address change");
        expect_at(1, K_DOE, 0, "R2 new access pending");
        expect_at(T_ACC + 1, K_DOE, 1, "R2 new access done");
        expect_at(T_ACC + 1, K_DOUT, word_of(8'h5a, 16'h00ff), "R2 new word");
        tick(T_ACC + 3);

        // Standby regardless of OE, sleep flag independent of CE (R4, R1).
        ce_n = 1'b1; oe_n = 1'b0; addr = 8'h11;
        expect_at(1, K_MODE, M_STBY, "R4 standby");
        expect_at(1, K_DOE, 0, "R4 standby tristate with oe low");
        expect_at(T_ACC + T_MARGIN + 1, K_LP, 0, "R3 oe low in standby");
        tick(T_ACC + T_MARGIN + 1);
        oe_n = 1'b1;
        expect_at(1, K_LP, 1, "R1 sleep while deselected");
        tick(2);

        // Deselect during an embedded operation (R5, R7).
        eng_busy = 1'b1;
        expect_at(1, K_MODE, M_ACT, "R5 busy keeps active");
        expect_at(1, K_READY, 0, "R7 busy not ready");
        tick(3);
        eng_busy = 1'b0;
        expect_at(1, K_MODE, M_STBY, "R5 standby after busy");
        expect_at(1, K_READY, 1, "R7 ready after busy");
        tick(2);

        // Command gate and a short reset pulse that must be ignored (R12, R6).
        ce_n = 1'b0; we_n = 1'b0;
        expect_at(1, K_CMD, 1, "R12 command accepted");
        tick(1);
        hw_rst_n = 1'b0;
        expect_at(1, K_CMD, 0, "R6 pin low blocks command");
        expect_at(T_RP - 1, K_CMD, 0, "R6 pin low blocks command late");
        expect_at(T_RP - 1, K_DECCLR, 0, "R6 short pulse not qualified");
        tick(T_RP - 1);
        hw_rst_n = 1'b1;
        expect_at(1, K_CMD, 1, "R6 short pulse ignored");
        expect_at(1, K_MODE, M_ACT, "R6 mode unchanged by short pulse");
        tick(1);
        we_n = 1'b1;
        expect_at(1, K_CMD, 0, "R12 write strobe released");
        tick(2);

        // Reset during a running operation (R6, R7, R9).
        oe_n = 1'b0; eng_busy = 1'b1; hw_rst_n = 1'b0;
        expect_at(T_RP - 1, K_DECCLR, 0, "R6 one edge before qualify");
        expect_at(T_RP, K_MODE, M_RST, "R6 reset mode");
        expect_at(T_RP, K_DECCLR, 1, "R6 decoder cleared");
        expect_at(T_RP, K_ABORT, 1, "R6 engine abort");
        expect_at(T_RP, K_DOE, 0, "R6 outputs tristated");
        expect_at(T_RP + 1, K_ABORT, 0, "R6 abort is one cycle");
        expect_at(T_RP + T_RDY_BUSY - 1, K_READY, 0, "R7 busy held");
        expect_at(T_RP + T_RDY_BUSY, K_READY, 1, "R7 busy released");
        expect_at(T_RP + 3, K_MODE, M_REC, "R9 recovery after release");
        expect_at(T_RP + 3, K_DOE, 0, "R9 no read in recovery");
        expect_at(T_RP + T_RDY_BUSY, K_MODE, M_REC, "R9 recovery waits for busy");
        expect_at(T_RP + T_RDY_BUSY + 1, K_MODE, M_ACT, "R9 back to active");
        expect_at(T_RP + T_RDY_BUSY + T_ACC, K_DOE, 0, "R9 access pending after reset");
        expect_at(T_RP + T_RDY_BUSY + T_ACC + 1, K_DOE, 1, "R9 read after reset");
        expect_at(T_RP + T_RDY_BUSY + T_ACC + 1, K_DOUT, word_of(8'h11, 16'h00ff),
                  "R9 array read after reset");
        tick(T_RP);
        eng_busy = 1'b0;
        tick(2);
        hw_rst_n = 1'b1;
        tick(T_RDY_BUSY + T_ACC + 2);

        // Reset with no operation running (R8).
        hw_rst_n = 1'b0;
        expect_at(T_RP, K_MODE, M_RST, "R8 idle reset mode");
        expect_at(T_RP, K_READY, 1, "R8 ready stays high");
        expect_at(T_RP, K_ABORT, 0, "R8 no abort");
        expect_at(T_RP + 1, K_READY, 1, "R8 ready stays high later");
        expect_at(T_RP + 3, K_MODE, M_REC, "R8 recovery");
        expect_at(T_RP + 4, K_MODE, M_ACT, "R8 idle recovery bound");
        tick(T_RP);
        hw_rst_n = 1'b1;
        tick(8);

        if (sb.size() != 0) begin
            n_bad += sb.size();
            $display("FAIL leftover expectations actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule